// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block turns 32-bit virtual byte addresses into physical ones through a small, fully associative table of page mappings with 4 KB pages. The upper 20 bits of a request address are compared against every stored entry at once. When an entry matches, its frame number takes the place of the page number and the 12-bit offset passes through unchanged. The entry's rights for loads, stores and instruction fetches are checked against the kind of access. The entry's cacheable flag is driven out so that device pages can avoid any cache.

Any access that cannot complete raises a trap in the same cycle. This covers a missing or invalid mapping and any use the entry does not permit. A trap-address register then records the faulting word address and a 2-bit reason. Refill is done by software. The handler reads the entry data port, which always shows the entry for the page held in the trap-address register. Writing that port installs a mapping for that page. The write either updates the existing entry for the page in place or claims a victim chosen round-robin, skipping the most recently used entry. A global enable turns translation off entirely.

Top module: `tlb_xlate`

## Requirements
- R1: While `xlat_en` is 0, `rsp_paddr` equals `req_vaddr`, `rsp_cache_en` is 1, `rsp_trap` and `rsp_cause` are 0.
- R2: While `xlat_en` is 1 and a valid entry matches `req_vaddr[31:12]` and permits the access, `rsp_paddr` is {entry frame, `req_vaddr[11:0]`} and no trap is raised.
- R3: While `xlat_en` is 1 and no valid entry matches the page, `rsp_paddr` is 0 and `rsp_cache_en` is 0. If `req_valid` is also 1, `rsp_trap` is 1 with `rsp_cause` 0.
- R4: `req_kind` encodes the access as 1 load, 2 store, 3 fetch, with 0 treated as a load. A matching entry without the needed right gives `rsp_paddr` 0 and `rsp_cache_en` 0. With `req_valid` it also gives a trap with cause 1 (load), 2 (store) or 3 (fetch). Entry control bits are [4] cacheable, [3] load, [2] store, [1] fetch, [0] valid.
- R5: In the clock edge after a trap, `ta_q` becomes {`req_vaddr[31:2]`, cause}. Without a trap, `ta_wr_en` loads `ta_wr_data` into it. A trap takes priority over the write.
- R6: `ent_rd_data` shows {frame in [31:12], zeros in [11:5], control in [4:0]} of the valid entry whose page equals `ta_q[31:12]`. It is all zeros when there is no such entry.
- R7: `ent_wr_en` installs page `ta_q[31:12]` with frame `ent_wr_data[31:12]` and control `ent_wr_data[4:0]`. If a valid entry for that page exists, it is overwritten in place. Two valid entries never hold the same page.
- R8: An install that needs a new slot takes the round-robin pointer's slot. If that slot is the most recently used entry, it takes the next slot instead. The pointer then moves to one past the slot taken. The most recently used entry is the last one installed or, failing that in the same cycle, the last one matched by an enabled lookup.
- R9: After reset all entries are invalid, `ta_q` is 0, the pointer is at slot 0, and no entry counts as most recently used.
- R10: `rsp_cache_en` follows bit 4 of the matching entry when the access translates (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Global translation enable |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | Access kind: 1 load, 2 store, 3 fetch |
| req_vaddr | input | 32 | Virtual byte address |
| rsp_paddr | output | 32 | Physical byte address |
| rsp_cache_en | output | 1 | Access may be cached |
| rsp_trap | output | 1 | Access aborted, trap requested |
| rsp_cause | output | 2 | Trap reason |
| ta_wr_en | input | 1 | Write trap-address register |
| ta_wr_data | input | 32 | Value for trap-address register |
| ta_q | output | 32 | Trap-address register |
| ent_wr_en | input | 1 | Install entry for page in `ta_q` |
| ent_wr_data | input | 32 | Frame and control bits to install |
| ent_rd_data | output | 32 | Entry matching page in `ta_q` |

## Verification
A corrupted tag or a duplicated page shows up at once as a wrong `rsp_paddr`, or as a spurious or missing trap, on the first lookup of that page. It also shows as a wrong `ent_rd_data` as soon as `ta_q` names the page. A mis-advanced replacement pointer has no visible effect until a later install evicts the wrong slot. The next lookup of the evicted page then traps where the model expects a hit. Because of that, the reference model tracks pointer and recency every cycle, and the random phase uses a small page pool so that evictions are revisited quickly.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic cache;
    logic ld;
    logic st;
    logic fx;
    logic vld;
  } tlb_ctl_t;

  localparam int CTL_W = 5;

  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;
  localparam logic [1:0] KIND_FETCH = 2'd3;

  // right required by an access kind; kind 0 behaves as a load
  function automatic logic right_ok(tlb_ctl_t c, logic [1:0] kind);
    case (kind)
      KIND_STORE: right_ok = c.st;
      KIND_FETCH: right_ok = c.fx;
      default:    right_ok = c.ld;
    endcase
  endfunction

  // reason code: 0 no mapping, else the violated access kind
  function automatic logic [1:0] fault_code(logic mapped, logic [1:0] kind);
    if (!mapped)        fault_code = 2'd0;
    else if (kind == 0) fault_code = KIND_LOAD;
    else                fault_code = kind;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int PG_W  = 20,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PG_W-1:0]   lk_page,
  output logic [N-1:0]      lk_hit_vec,
  output logic [PG_W-1:0]   lk_frame,
  output tlb_ctl_t          lk_ctl,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [PG_W-1:0]   pr_page,
  output logic [N-1:0]      pr_hit_vec,
  output logic [PG_W-1:0]   pr_frame,
  output tlb_ctl_t          pr_ctl,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PG_W-1:0]   wr_frame,
  input  tlb_ctl_t          wr_ctl
);

  logic [PG_W-1:0] tag_q [N];
  logic [PG_W-1:0] frm_q [N];
  tlb_ctl_t        ctl_q [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[e] <= '0;
        frm_q[e] <= '0;
        ctl_q[e] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        tag_q[e] <= pr_page;
        frm_q[e] <= wr_frame;
        ctl_q[e] <= wr_ctl;
      end
    end
    assign lk_hit_vec[e] = ctl_q[e].vld && (tag_q[e] == lk_page);
    assign pr_hit_vec[e] = ctl_q[e].vld && (tag_q[e] == pr_page);
  end

  always_comb begin
    lk_frame = '0;
    lk_ctl   = '0;
    lk_idx   = '0;
    pr_frame = '0;
    pr_ctl   = '0;
    pr_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_hit_vec[i]) begin
        lk_frame = lk_frame | frm_q[i];
        lk_ctl   = lk_ctl | ctl_q[i];
        lk_idx   = lk_idx | IDX_W'(i);
      end
      if (pr_hit_vec[i]) begin
        pr_frame = pr_frame | frm_q[i];
        pr_ctl   = pr_ctl | ctl_q[i];
        pr_idx   = pr_idx | IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [IDX_W-1:0] mru_idx,
  input  logic             mru_vld,
  output logic [IDX_W-1:0] victim_idx
);

  function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] v);
    step = (v == IDX_W'(N - 1)) ? '0 : v + 1'b1;
  endfunction

  logic [IDX_W-1:0] ptr_q;

  assign victim_idx = (mru_vld && ptr_q == mru_idx) ? step(ptr_q) : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (alloc) ptr_q <= step(victim_idx);
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int PG_W  = 20,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xlat_en,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [PG_W+OFF_W-1:0]  req_vaddr,
  output logic [PG_W+OFF_W-1:0]  rsp_paddr,
  output logic                   rsp_cache_en,
  output logic                   rsp_trap,
  output logic [1:0]             rsp_cause,
  input  logic                   ta_wr_en,
  input  logic [PG_W+OFF_W-1:0]  ta_wr_data,
  output logic [PG_W+OFF_W-1:0]  ta_q,
  input  logic                   ent_wr_en,
  input  logic [PG_W+OFF_W-1:0]  ent_wr_data,
  output logic [PG_W+OFF_W-1:0]  ent_rd_data
);

  localparam int VA_W  = PG_W + OFF_W;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int GAP_W = OFF_W - CTL_W;

  logic [N-1:0]     lk_hit_vec, pr_hit_vec;
  logic [PG_W-1:0]  lk_frame, pr_frame;
  tlb_ctl_t         lk_ctl, pr_ctl;
  logic [IDX_W-1:0] lk_idx, pr_idx;
  logic [IDX_W-1:0] victim_idx, wr_idx, mru_idx;
  logic             mru_vld;

  // named internal events
  logic lk_used, lk_any, lk_ok, pr_any, alloc_fire;
  logic [1:0] code;
  logic [GAP_W-1:0] wr_rsvd_unused;

  tlb_cam #(.N(N), .PG_W(PG_W), .IDX_W(IDX_W)) cam_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_page    (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit_vec (lk_hit_vec),
    .lk_frame   (lk_frame),
    .lk_ctl     (lk_ctl),
    .lk_idx     (lk_idx),
    .pr_page    (ta_q[VA_W-1:OFF_W]),
    .pr_hit_vec (pr_hit_vec),
    .pr_frame   (pr_frame),
    .pr_ctl     (pr_ctl),
    .pr_idx     (pr_idx),
    .wr_en      (ent_wr_en),
    .wr_idx     (wr_idx),
    .wr_frame   (ent_wr_data[VA_W-1:OFF_W]),
    .wr_ctl     (tlb_ctl_t'(ent_wr_data[CTL_W-1:0]))
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) vic_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (alloc_fire),
    .mru_idx    (mru_idx),
    .mru_vld    (mru_vld),
    .victim_idx (victim_idx)
  );

  assign wr_rsvd_unused = ent_wr_data[OFF_W-1:CTL_W];

  assign lk_used = req_valid && xlat_en;
  assign lk_any  = |lk_hit_vec;
  assign lk_ok   = lk_any && lk_ctl.vld && right_ok(lk_ctl, req_kind);
  assign code    = fault_code(lk_any, req_kind);

  always_comb begin
    if (!xlat_en) begin
      rsp_paddr    = req_vaddr;
      rsp_cache_en = 1'b1;
    end else if (lk_ok) begin
      rsp_paddr    = {lk_frame, req_vaddr[OFF_W-1:0]};
      rsp_cache_en = lk_ctl.cache;
    end else begin
      rsp_paddr    = '0;
      rsp_cache_en = 1'b0;
    end
  end

  assign rsp_trap  = lk_used && !lk_ok;
  assign rsp_cause = rsp_trap ? code : 2'd0;

  // trap-address register: a trap overrides a software write
  always_ff @(posedge clk) begin
    if (!rst_n)        ta_q <= '0;
    else if (rsp_trap) ta_q <= {req_vaddr[VA_W-1:2], code};
    else if (ta_wr_en) ta_q <= ta_wr_data;
  end

  assign pr_any      = |pr_hit_vec;
  assign alloc_fire  = ent_wr_en && !pr_any;
  assign wr_idx      = pr_any ? pr_idx : victim_idx;
  assign ent_rd_data = pr_any ? {pr_frame, {GAP_W{1'b0}}, pr_ctl} : '0;

  // recency: installs win over lookups in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mru_idx <= '0;
      mru_vld <= 1'b0;
    end else if (ent_wr_en) begin
      mru_idx <= wr_idx;
      mru_vld <= 1'b1;
    end else if (lk_used && lk_any) begin
      mru_idx <= lk_idx;
      mru_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/tlb_xlate_sva.sv
module tlb_xlate_sva #(
  parameter int N     = 8,
  parameter int PG_W  = 20,
  parameter int OFF_W = 12,
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xlat_en,
  input logic                  req_valid,
  input logic [PG_W+OFF_W-1:0] req_vaddr,
  input logic [PG_W+OFF_W-1:0] rsp_paddr,
  input logic                  rsp_trap,
  input logic [1:0]            rsp_cause,
  input logic                  ta_wr_en,
  input logic [PG_W+OFF_W-1:0] ta_q,
  input logic                  ent_wr_en,
  input logic [PG_W+OFF_W-1:0] ent_wr_data,
  input logic [N-1:0]          lk_hit_vec,
  input logic [N-1:0]          pr_hit_vec,
  input logic                  alloc_fire,
  input logic [IDX_W-1:0]      victim_idx,
  input logic [IDX_W-1:0]      mru_idx,
  input logic                  mru_vld
);

  localparam int VA_W = PG_W + OFF_W;

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_en |-> (rsp_paddr == req_vaddr && !rsp_trap));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_en && !rsp_trap) |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  assert_trap_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |=> ta_q == {$past(req_vaddr[VA_W-1:2]), $past(rsp_cause)});

  assert_single_lookup_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  assert_single_probe_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pr_hit_vec));

  assert_install_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_wr_en && ent_wr_data[0] && !rsp_trap && !ta_wr_en) |=> (pr_hit_vec != '0));

  assert_mru_spared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && mru_vld) |-> victim_idx != mru_idx);

endmodule

bind tlb_xlate tlb_xlate_sva #(.N(N), .PG_W(PG_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) sva_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .xlat_en     (xlat_en),
  .req_valid   (req_valid),
  .req_vaddr   (req_vaddr),
  .rsp_paddr   (rsp_paddr),
  .rsp_trap    (rsp_trap),
  .rsp_cause   (rsp_cause),
  .ta_wr_en    (ta_wr_en),
  .ta_q        (ta_q),
  .ent_wr_en   (ent_wr_en),
  .ent_wr_data (ent_wr_data),
  .lk_hit_vec  (lk_hit_vec),
  .pr_hit_vec  (pr_hit_vec),
  .alloc_fire  (alloc_fire),
  .victim_idx  (victim_idx),
  .mru_idx     (mru_idx),
  .mru_vld     (mru_vld)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0, req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] rsp_paddr;
  logic        rsp_cache_en, rsp_trap;
  logic [1:0]  rsp_cause;
  logic        ta_wr_en = 1'b0;
  logic [31:0] ta_wr_data = '0;
  logic [31:0] ta_q;
  logic        ent_wr_en = 1'b0;
  logic [31:0] ent_wr_data = '0;
  logic [31:0] ent_rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_xlate #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_valid(req_valid),
    .req_kind(req_kind), .req_vaddr(req_vaddr), .rsp_paddr(rsp_paddr),
    .rsp_cache_en(rsp_cache_en), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
    .ta_wr_en(ta_wr_en), .ta_wr_data(ta_wr_data), .ta_q(ta_q),
    .ent_wr_en(ent_wr_en), .ent_wr_data(ent_wr_data), .ent_rd_data(ent_rd_data)
  );

  // reference model state
  logic [19:0] m_tag [N];
  logic [19:0] m_frm [N];
  logic [4:0]  m_ctl [N];
  int          m_ptr, m_mru;
  bit          m_mruv;
  logic [31:0] m_ta;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_find(logic [19:0] pg);
    int r = -1;
    foreach (m_tag[i]) if (m_ctl[i][0] && m_tag[i] == pg) r = i;
    return r;
  endfunction

  function automatic bit m_right(logic [4:0] c, logic [1:0] k);
    if (k == 2) return c[2];
    if (k == 3) return c[1];
    return c[3];
  endfunction

  task automatic m_reset();
    foreach (m_tag[i]) begin m_tag[i] = 0; m_frm[i] = 0; m_ctl[i] = 0; end
    m_ptr = 0; m_mru = 0; m_mruv = 0; m_ta = 0;
  endtask

  // one clock: drive, compare combinational outputs, model the edge
  task automatic cyc(bit en, bit v, logic [1:0] k, logic [31:0] va,
                     bit taw, logic [31:0] tawd, bit ew, logic [31:0] ewd);
    int idx, pidx, tgt;
    bit ok, trap;
    logic [1:0] cause;
    logic [31:0] e_pa, e_rd;
    bit e_ce;
    xlat_en = en; req_valid = v; req_kind = k; req_vaddr = va;
    ta_wr_en = taw; ta_wr_data = tawd; ent_wr_en = ew; ent_wr_data = ewd;
    #1;
    idx = m_find(va[31:12]);
    ok = (idx >= 0) && m_right(m_ctl[idx], k);
    trap = en && v && !ok;
    cause = (idx < 0) ? 2'd0 : ((k == 0) ? 2'd1 : k);
    if (!en) begin e_pa = va; e_ce = 1; end
    else if (ok) begin e_pa = {m_frm[idx], va[11:0]}; e_ce = m_ctl[idx][4]; end
    else begin e_pa = 0; e_ce = 0; end
    if (!en) chk("R1 paddr", rsp_paddr, e_pa);
    else     chk("R2 paddr", rsp_paddr, e_pa);
    chk("R10 cache_en", {31'd0, rsp_cache_en}, {31'd0, e_ce});
    chk("R3 trap", {31'd0, rsp_trap}, {31'd0, trap});
    chk("R4 cause", {30'd0, rsp_cause}, trap ? {30'd0, cause} : 32'd0);
    chk("R5 ta", ta_q, m_ta);
    pidx = m_find(m_ta[31:12]);
    e_rd = (pidx < 0) ? 32'd0 : {m_frm[pidx], 7'd0, m_ctl[pidx]};
    chk("R6 rd_data", ent_rd_data, e_rd);
    @(posedge clk);
    if (ew) begin
      if (pidx >= 0) tgt = pidx;
      else begin
        tgt = (m_mruv && m_ptr == m_mru) ? (m_ptr + 1) % N : m_ptr;
        m_ptr = (tgt + 1) % N;
      end
      m_tag[tgt] = m_ta[31:12]; m_frm[tgt] = ewd[31:12]; m_ctl[tgt] = ewd[4:0];
      m_mru = tgt; m_mruv = 1;
    end else if (en && v && idx >= 0) begin
      m_mru = idx; m_mruv = 1;
    end
    if (trap) m_ta = {va[31:2], cause};
    else if (taw) m_ta = tawd;
    @(negedge clk);
  endtask

  task automatic look(logic [1:0] k, logic [31:0] va);
    cyc(1, 1, k, va, 0, 0, 0, 0);
  endtask

  task automatic set_ta(logic [31:0] v);
    cyc(1, 0, 0, 0, 1, v, 0, 0);
  endtask

  task automatic put(logic [19:0] frame, logic [4:0] c);
    cyc(1, 0, 0, 0, 0, 0, 1, {frame, 7'd0, c});
  endtask

  initial begin
    logic [31:0] lf;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state observed at the ports
    chk("R9 ta after reset", ta_q, 0);
    chk("R9 rd after reset", ent_rd_data, 0);
    xlat_en = 1; req_valid = 1; req_vaddr = 32'h0000_0123; #1;
    chk("R9 page 0 not mapped", {31'd0, rsp_trap}, 1);
    @(negedge clk);
    m_reset();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;

    // R1 bypass
    cyc(0, 1, 1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cyc(0, 1, 3, 32'h0000_1004, 0, 0, 0, 0);
    // R3 miss, R5 capture
    look(1, 32'h1234_5678);
    chk("R5 captured word and cause", ta_q, 32'h1234_5678 & 32'hFFFF_FFFC);
    // R7 install for trapped page: cacheable, load, valid
    put(20'hABCDE, 5'b11001);
    look(1, 32'h1234_5ABC);
    chk("R2 translated", rsp_paddr, 32'hABCD_EABC);
    look(2, 32'h1234_5000);   // store violation R4
    look(3, 32'h1234_5010);   // fetch violation R4
    chk("R4 fetch cause in ta", {30'd0, ta_q[1:0]}, 3);
    look(0, 32'h1234_5020);   // kind 0 as load
    // store-only page: load violation
    set_ta(32'h0000_7000);
    put(20'h00042, 5'b00101);
    look(1, 32'h0000_7FFC);
    look(2, 32'h0000_7FFC);
    // R7 overwrite in place
    set_ta(32'h1234_5000);
    put(20'h11111, 5'b01111);
    look(3, 32'h1234_5444);
    chk("R7 overwrite in place", rsp_paddr, 32'h1111_1444);
    // trap beats software write R5
    cyc(1, 1, 1, 32'h5555_5004, 1, 32'h0000_0000, 0, 0);
    chk("R5 trap priority", ta_q, 32'h5555_5004);
    // fill past capacity with MRU reuse; R8
    for (int i = 0; i < 12; i++) begin
      set_ta({20'h00100 + 20'(i), 12'h0});
      put(20'h80000 + 20'(i), 5'b11111);
      look(1, {20'h00100 + 20'(i), 12'h0});
    end
    look(1, 32'h0010_B000);
    set_ta(32'h0020_0000);
    put(20'h7777, 5'b11111);
    look(1, 32'h0010_B008);
    chk("R8 recent entry spared", {31'd0, rsp_trap}, 0);
    // disable with entries present R1
    cyc(0, 1, 2, 32'h0010_B008, 0, 0, 0, 0);
    // pseudo-random phase over a small page pool
    lf = 32'hACE1_2345;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc(lf[3:0] != 0, lf[4], lf[6:5], {20'(lf[10:7] % 12), lf[22:11]},
          lf[23] & lf[24], {20'(lf[28:25] % 12), lf[31:20]},
          lf[25] & lf[26], {lf[19:0] ^ lf[31:12], 7'd0, lf[29:26] == 0 ? 5'b00000 : lf[31:27]});
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule